// File: doc/BRIEF.md
# Pixel Column Token Readout

This block is the digital half of one column of hit-detecting pixel cells, together with the control logic that reads the column out. Each cell has two kinds of comparator input. A main comparator says whether the cell was hit at all. Seven amplitude comparators form a thermometer-style code. A 2-bit column command selects the mode, and every mode acts on the next rising edge of the read clock:

- Arm mode latches new hits and their amplitudes.
- Clear mode wipes all stored hits and the read outputs.
- Read mode empties the column one hit per clock.
- Idle mode holds everything.

Readout is zero-suppressed. While the token input is high in read mode, each clock the pending cell with the lowest row number (row 0 is the top of the column) is read. The read presents the cell's row number and its 3-bit amplitude on shared registered outputs, and the cell's stored hit is cleared. Empty cells take no read cycles. Once no pending cell remains, the token passes on to the next column. A per-cell kill mask silences noisy cells. Two fast-OR flags let the periphery see activity without a read: one for stored hits and one for live comparator hits.

The amplitude code is the count of set comparator bits. A non-monotonic thermometer pattern therefore still yields a value from 0 to 7. Hit capture is a plain synchronous register in every cell. Any number of cells can fire in the same cycle, and all of them are captured together, with no race that could hang the readout.

Top module: `pixcol_readout`

## Requirements
- R1: After rst_ni is released, no hit is stored, rd_valid_o, row_o and adc_o are 0 and fast_or_lat_o is 0.
- R2: With cmd_i = 2'b11 (arm), each cell whose hit_cmp_i bit is 1 and whose kill_i bit is 0 stores a hit at the clock edge. A cell that already holds a hit keeps the amplitude from its first capture.
- R3: A cell with kill_i = 1 stores no hit in arm mode. A stored hit in a cell whose kill_i is 1 is neither reported nor counted in fast_or_lat_o, but it is kept.
- R4: With cmd_i = 2'b10 (read), tok_i = 1 and tok_clr_i = 0, each edge reads the lowest-numbered pending cell and clears its hit. In the next cycle rd_valid_o = 1, row_o = that row and adc_o = its amplitude. In any cycle without a read, rd_valid_o, row_o and adc_o are 0.
- R5: A read sequence reports every pending unkilled cell exactly once, in strictly increasing row order, on consecutive cycles.
- R6: tok_o is 1 exactly when cmd_i = 2'b10, tok_i = 1, tok_clr_i = 0 and no unkilled cell is pending (combinational).
- R7: With cmd_i = 2'b01 (clear), all stored hits and the read outputs are cleared at the edge.
- R8: With cmd_i = 2'b00 (idle), stored hits are unchanged and no read occurs.
- R9: While tok_clr_i = 1, no read occurs, the read outputs are cleared and tok_o is 0. Stored hits are kept.
- R10: fast_or_lat_o is the OR of stored unkilled hits. fast_or_raw_o is the OR of hit_cmp_i bits of unkilled cells (combinational).
- R11: When all 128 cells are hit in the same arm cycle, all are stored, and exactly 128 consecutive reads then drain the column.
- R12: The amplitude is the number of 1 bits among the cell's 7 thermometer inputs (cell r uses thermo_i[7r+6:7r]), including non-monotonic patterns.
- R13: In read mode with tok_i = 0, no read occurs and tok_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2 | Column command: 00 idle, 01 clear, 10 read, 11 arm |
| hit_cmp_i | input | N_ROWS | Main threshold comparator per cell |
| thermo_i | input | N_ROWS*N_THR | Amplitude comparators, N_THR bits per cell |
| kill_i | input | N_ROWS | Per-cell kill mask |
| tok_i | input | 1 | Token in |
| tok_clr_i | input | 1 | Token reset; aborts reading while high |
| tok_o | output | 1 | Token out |
| rd_valid_o | output | 1 | Read data valid |
| row_o | output | ROW_W | Row address of the cell read |
| adc_o | output | AMP_W | Binary amplitude of the cell read |
| fast_or_lat_o | output | 1 | Some unkilled cell holds a stored hit |
| fast_or_raw_o | output | 1 | Some unkilled cell's comparator is high now |

## Verification
The bound checker watches the following on every cycle:
- a read is only ever reported after a cycle with read mode, token present and no token reset, while a stored hit was flagged;
- consecutive reads carry strictly rising row numbers;
- the token never leaves while a hit is still pending;
- clear, idle and token-reset cycles are never followed by a read.

Only the bench's scenarios can show the rest:
- every unkilled hit comes out exactly once with the right popcount amplitude;
- the first captured amplitude survives a second arm cycle;
- killed cells stay silent but keep a stored hit;
- a fully hit column drains in exactly 128 cycles.

// File: rtl/pixcol_pkg.sv
package pixcol_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_CLEAR = 2'b01,
    CMD_READ  = 2'b10,
    CMD_ARM   = 2'b11
  } col_cmd_e;
endpackage

// File: rtl/pixcol_cell.sv
module pixcol_cell #(
  parameter int N_THR = 7,
  parameter int AMP_W = $clog2(N_THR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             wipe_i,
  input  logic             take_i,
  input  logic             cmp_i,
  input  logic [N_THR-1:0] thermo_i,
  input  logic             kill_i,
  output logic             pend_o,
  output logic [AMP_W-1:0] amp_o
);
  logic             hit_q;
  logic [AMP_W-1:0] amp_q;
  logic [AMP_W-1:0] amp_enc;

  // popcount: tolerant of bubbles in the thermometer code
  always_comb begin
    amp_enc = '0;
    for (int i = 0; i < N_THR; i++) amp_enc = amp_enc + AMP_W'(thermo_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      amp_q <= '0;
    end else if (wipe_i) begin
      hit_q <= 1'b0;
      amp_q <= '0;
    end else if (take_i) begin
      hit_q <= 1'b0;
    end else if (arm_i && cmp_i && !kill_i && !hit_q) begin
      hit_q <= 1'b1;
      amp_q <= amp_enc;
    end
  end

  assign pend_o = hit_q & ~kill_i;
  assign amp_o  = amp_q;
endmodule

// File: rtl/pixcol_arb.sv
module pixcol_arb #(
  parameter int N     = 128,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     gnt_o
);
  // lowest index wins: nearest the top of the column
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
  assign gnt_o = any_o ? (N'(1) << idx_o) : '0;
endmodule

// File: rtl/pixcol_ctrl.sv
module pixcol_ctrl
  import pixcol_pkg::*;
#(
  parameter int ROW_W = 7,
  parameter int AMP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cmd_i,
  input  logic             tok_i,
  input  logic             tok_clr_i,
  input  logic             any_i,
  input  logic [ROW_W-1:0] idx_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic             arm_o,
  output logic             wipe_o,
  output logic             fire_o,
  output logic             tok_o,
  output logic             rd_valid_o,
  output logic [ROW_W-1:0] row_o,
  output logic [AMP_W-1:0] adc_o
);
  col_cmd_e   cmd;
  logic       rd_mode;

  assign cmd     = col_cmd_e'(cmd_i);
  assign arm_o   = (cmd == CMD_ARM);
  assign wipe_o  = (cmd == CMD_CLEAR);
  assign rd_mode = (cmd == CMD_READ) && tok_i && !tok_clr_i;
  assign fire_o  = rd_mode && any_i;
  assign tok_o   = rd_mode && !any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      row_o      <= '0;
      adc_o      <= '0;
    end else if (fire_o) begin
      rd_valid_o <= 1'b1;
      row_o      <= idx_i;
      adc_o      <= amp_i;
    end else begin
      rd_valid_o <= 1'b0;
      row_o      <= '0;
      adc_o      <= '0;
    end
  end
endmodule

// File: rtl/pixcol_readout.sv
module pixcol_readout #(
  parameter int N_ROWS = 128,
  parameter int N_THR  = 7,
  parameter int ROW_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  parameter int AMP_W  = $clog2(N_THR + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              cmd_i,
  input  logic [N_ROWS-1:0]       hit_cmp_i,
  input  logic [N_ROWS*N_THR-1:0] thermo_i,
  input  logic [N_ROWS-1:0]       kill_i,
  input  logic                    tok_i,
  input  logic                    tok_clr_i,
  output logic                    tok_o,
  output logic                    rd_valid_o,
  output logic [ROW_W-1:0]        row_o,
  output logic [AMP_W-1:0]        adc_o,
  output logic                    fast_or_lat_o,
  output logic                    fast_or_raw_o
);
  logic [N_ROWS-1:0] pend;
  logic [N_ROWS-1:0] gnt;
  logic [AMP_W-1:0]  amp_arr [N_ROWS];
  logic              any_pend;
  logic [ROW_W-1:0]  sel_idx;
  logic              arm, wipe, fire;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_cell
    pixcol_cell #(.N_THR(N_THR), .AMP_W(AMP_W)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (arm),
      .wipe_i   (wipe),
      .take_i   (fire & gnt[r]),
      .cmp_i    (hit_cmp_i[r]),
      .thermo_i (thermo_i[r*N_THR +: N_THR]),
      .kill_i   (kill_i[r]),
      .pend_o   (pend[r]),
      .amp_o    (amp_arr[r])
    );
  end

  pixcol_arb #(.N(N_ROWS), .IDX_W(ROW_W)) u_arb (
    .req_i (pend),
    .any_o (any_pend),
    .idx_o (sel_idx),
    .gnt_o (gnt)
  );

  pixcol_ctrl #(.ROW_W(ROW_W), .AMP_W(AMP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .tok_i      (tok_i),
    .tok_clr_i  (tok_clr_i),
    .any_i      (any_pend),
    .idx_i      (sel_idx),
    .amp_i      (amp_arr[sel_idx]),
    .arm_o      (arm),
    .wipe_o     (wipe),
    .fire_o     (fire),
    .tok_o      (tok_o),
    .rd_valid_o (rd_valid_o),
    .row_o      (row_o),
    .adc_o      (adc_o)
  );

  assign fast_or_lat_o = any_pend;
  assign fast_or_raw_o = |(hit_cmp_i & ~kill_i);
endmodule

// File: rtl/pixcol_readout_chk.sv
module pixcol_readout_chk #(
  parameter int ROW_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cmd_i,
  input logic             tok_i,
  input logic             tok_clr_i,
  input logic             tok_o,
  input logic             rd_valid_o,
  input logic [ROW_W-1:0] row_o,
  input logic             fast_or_lat_o
);
  a_r4_read_needs_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_i == 2'b10 && tok_i && !tok_clr_i));

  a_r10_read_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(fast_or_lat_o));

  a_r5_rows_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_valid_o)) |-> (row_o > $past(row_o)));

  a_r6_token_only_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_o |-> !fast_or_lat_o);

  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'b01) |=> (!fast_or_lat_o && !rd_valid_o));

  a_r8_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'b00) |=> !rd_valid_o);

  a_r9_tok_clr_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_clr_i |=> !rd_valid_o);

  a_r13_no_token_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_i |-> !tok_o);
endmodule

bind pixcol_readout pixcol_readout_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_i         (cmd_i),
  .tok_i         (tok_i),
  .tok_clr_i     (tok_clr_i),
  .tok_o         (tok_o),
  .rd_valid_o    (rd_valid_o),
  .row_o         (row_o),
  .fast_or_lat_o (fast_or_lat_o)
);

// File: tb/pixcol_readout_test.sv
module pixcol_readout_test;
  localparam int N  = 128;
  localparam int T  = 7;
  localparam int RW = 7;
  localparam int AW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      cmd = 2'b00;
  logic [N-1:0]    cmp = '0;
  logic [N*T-1:0]  thermo = '0;
  logic [N-1:0]    kill = '0;
  logic            tok = 1'b0;
  logic            tok_clr = 1'b0;
  logic            tok_out, rd_valid, fo_lat, fo_raw;
  logic [RW-1:0]   row;
  logic [AW-1:0]   adc;

  int total = 0;
  int bad = 0;
  bit exp_hit [N];
  int exp_amp [N];

  always #2 clk = ~clk;

  pixcol_readout uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .hit_cmp_i(cmp), .thermo_i(thermo),
    .kill_i(kill), .tok_i(tok), .tok_clr_i(tok_clr), .tok_o(tok_out),
    .rd_valid_o(rd_valid), .row_o(row), .adc_o(adc),
    .fast_or_lat_o(fo_lat), .fast_or_raw_o(fo_raw)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_any();
    for (int r = 0; r < N; r++) if (exp_hit[r] && !kill[r]) return 1;
    return 0;
  endfunction

  // R2 R3 R12: model capture at the arm edge
  task automatic arm_cycle();
    cmd = 2'b11;
    for (int r = 0; r < N; r++)
      if (cmp[r] && !kill[r] && !exp_hit[r]) begin
        exp_hit[r] = 1'b1;
        exp_amp[r] = $countones(thermo[r*T +: T]);
      end
    step();
    cmd = 2'b00;
  endtask

  // R4 R5 R6: drain with token present
  task automatic read_all(string tag);
    cmd = 2'b10;
    tok = 1'b1;
    for (int r = 0; r < N; r++) begin
      if (exp_hit[r] && !kill[r]) begin
        step();
        chk({"R4 valid ", tag}, int'(rd_valid), 1);
        chk({"R5 row ", tag}, int'(row), r);
        chk({"R12 adc ", tag}, int'(adc), exp_amp[r]);
        exp_hit[r] = 1'b0;
      end
    end
    #1;
    chk({"R6 token out ", tag}, int'(tok_out), 1);
    chk({"R10 fast_or empty ", tag}, int'(fo_lat), 0);
    step();
    chk({"R4 no read when empty ", tag}, int'(rd_valid), 0);
    cmd = 2'b00;
    tok = 1'b0;
  endtask

  task automatic rand_inputs(int hit_pct, int kill_pct);
    for (int r = 0; r < N; r++) begin
      cmp[r]  = (($urandom % 100) < hit_pct);
      kill[r] = (($urandom % 100) < kill_pct);
      thermo[r*T +: T] = T'($urandom);
    end
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < N; r++) begin exp_hit[r] = 1'b0; exp_amp[r] = 0; end
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 row", int'(row), 0);
    chk("R1 adc", int'(adc), 0);
    chk("R1 fast_or_lat", int'(fo_lat), 0);
    cmd = 2'b10; tok = 1'b1; #1;
    chk("R6 token passes on empty column", int'(tok_out), 1);
    tok = 1'b0; #1;
    chk("R13 no token in no token out", int'(tok_out), 0);
    cmd = 2'b00;

    // R12 directed thermometer patterns, including bubbles
    cmp[5] = 1'b1; thermo[5*T +: T] = 7'b1010101;
    cmp[9] = 1'b1; thermo[9*T +: T] = 7'b0000000;
    cmp[3] = 1'b1; thermo[3*T +: T] = 7'b1111111;
    cmp[77] = 1'b1; thermo[77*T +: T] = 7'b0100000;
    arm_cycle();
    cmp = '0;
    chk("R10 fast_or after capture", int'(fo_lat), 1);
    read_all("directed");

    // R2 R3 R5 random rounds with a second arm cycle using new amplitudes
    for (int k = 0; k < 12; k++) begin
      rand_inputs(25, 12);
      arm_cycle();
      for (int r = 0; r < N; r++) thermo[r*T +: T] = T'($urandom);
      arm_cycle();
      chk("R10 fast_or random", int'(fo_lat), exp_any());
      cmp = '0;
      read_all("random");
    end
    kill = '0;

    // R8 idle holds hits
    cmp = '0; cmp[2] = 1'b1; cmp[60] = 1'b1; cmp[127] = 1'b1;
    for (int r = 0; r < N; r++) thermo[r*T +: T] = T'($urandom);
    arm_cycle();
    cmp = '0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R8 idle no read", int'(rd_valid), 0);
      chk("R8 idle keeps hits", int'(fo_lat), 1);
    end
    read_all("after idle");

    // R13 read mode without token
    cmp[40] = 1'b1; cmp[41] = 1'b1;
    arm_cycle();
    cmp = '0;
    cmd = 2'b10; tok = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R13 no read without token", int'(rd_valid), 0);
      chk("R13 token out low", int'(tok_out), 0);
    end
    chk("R13 hits kept", int'(fo_lat), 1);
    read_all("after no token");

    // R9 token reset blocks reading
    cmp[0] = 1'b1; cmp[100] = 1'b1;
    arm_cycle();
    cmp = '0;
    cmd = 2'b10; tok = 1'b1; tok_clr = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9 no read under token reset", int'(rd_valid), 0);
      chk("R9 token out low", int'(tok_out), 0);
    end
    chk("R9 hits kept", int'(fo_lat), 1);
    tok_clr = 1'b0;
    read_all("after token reset");

    // R7 clear command
    rand_inputs(40, 0);
    arm_cycle();
    cmp = '0;
    chk("R7 hits present before clear", int'(fo_lat), exp_any());
    cmd = 2'b01;
    step();
    for (int r = 0; r < N; r++) exp_hit[r] = 1'b0;
    chk("R7 clear empties column", int'(fo_lat), 0);
    chk("R7 no read after clear", int'(rd_valid), 0);
    read_all("after clear");

    // R3 kill: blocks capture, masks a stored hit, keeps it
    cmp = '0; kill = '0;
    cmp[10] = 1'b1; cmp[20] = 1'b1; cmp[30] = 1'b1; kill[30] = 1'b1;
    thermo[10*T +: T] = 7'b0000111;
    thermo[20*T +: T] = 7'b0011111;
    arm_cycle();
    cmp = '0;
    kill[10] = 1'b1;
    #1;
    chk("R3 unkilled still flagged", int'(fo_lat), 1);
    read_all("kill masked");
    kill = '0;
    #1;
    chk("R3 masked hit kept", int'(fo_lat), 1);
    read_all("kill released");

    // R10 raw fast-OR
    cmp = '0; kill = '0; cmp[50] = 1'b1; kill[50] = 1'b1; #1;
    chk("R10 raw fast_or ignores killed", int'(fo_raw), 0);
    kill[50] = 1'b0; #1;
    chk("R10 raw fast_or live", int'(fo_raw), 1);
    cmp = '0; #1;
    chk("R10 raw fast_or idle", int'(fo_raw), 0);

    // R11 whole column hit in one cycle
    cmp = '1;
    for (int r = 0; r < N; r++) thermo[r*T +: T] = T'($urandom);
    arm_cycle();
    cmp = '0;
    read_all("full column R11");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule